// File: doc/BRIEF.md
# Clock Domain Source Select and Divider

This block produces the clock of one chip domain. It has five candidate input clocks: a slow real-time clock, a crystal oscillator and three PLL outputs. The selected clock can be divided down or passed straight through. Software programs it through one 32-bit configuration word, written and read on a simple register port in the control clock domain.

A source change is break-before-make. The old input is gated off on its own falling edge. The new input is gated on, again on its own falling edge, only after the old gate is seen to be closed. While this happens, a busy flag reads 1. The divider sets the high and low phases separately. A new high/low pair takes effect only through a commit bit, which hardware clears once the pair has been loaded at the end of a complete output period. A bypass bit passes the selected source through without division.

The same block serves two other kinds of domain. One has narrower count fields, so its maximum ratio is lower. The other is tied to the third PLL: its select field cannot be written.

Top module: `clk_domain_gen`

## Requirements
- R1: After reset the word reads select = 1, bypass (bit 24) = 1, high count = low count = 0, busy (bit 3) = 0 and commit (bit 25) = 0. A fixed-source instance reads select = 4.
- R2: A write of 0..4 to the select field (bits 2:0) makes the output follow input 0..4 once busy has cleared.
- R3: A write of a select value above 4 leaves the select field and the output source unchanged.
- R4: Busy (bit 3) reads 1 in the cycle after a write that changes the select field. It stays 1 until the new source drives the output, then returns to 0. Rewriting the current select leaves busy at 0.
- R5: At most one input gate is open at any time.
- R6: With bypass clear, the output period is W + H + 2 cycles of the selected input. It stays high for W + 1 cycles. W is the high count (bits 16 upward) and H is the low count (bits 20 upward).
- R7: For every ratio R from 2 to 2^(n+1), W = (R>>1) - 1 and H = R - W - 2 give a period of R cycles and a high time of R>>1 cycles. Here n is the count width.
- R8: With bypass (bit 24) set, the output has the period and duty of the selected input. Clearing bypass restores the divided clock.
- R9: A write with bit 25 set and no commit pending loads W and H, and bit 25 reads 1 until the new pair is in effect. A write with bit 25 clear leaves W, H and the output period unchanged.
- R10: A write with bit 25 set while a commit is pending leaves W and H unchanged.
- R11: With count width 3, each count field holds 3 bits, bits 19 and 23 read 0, and the largest ratio is 16.
- R12: A fixed-source instance ignores writes to the select field, reads 4 there, never shows busy, and outputs input 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for the register port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | NUM_SRC | Candidate source clocks, index = select code |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 32 | Configuration write word |
| rd_data_o | output | 32 | Configuration and status read word |
| clk_o | output | 1 | Domain output clock |

## Verification
A wrong internal state shows up at `clk_o` within one output period, as a wrong period or high time measured against the selected input. It can also show up in the read word in the very next control cycle. A lost synchroniser toggle leaves bit 3 or bit 25 stuck at 1, and the poll loop catches that. A gate opened too early would leave two inputs enabled at once, and the checker flags that on the next control edge. Bad field handling appears in the read-back straight after the write.

// File: rtl/dcg_pkg.sv
`timescale 1ns/1ps
package dcg_pkg;
  localparam int SEL_LSB    = 0;
  localparam int SEL_W      = 3;
  localparam int BUSY_BIT   = 3;
  localparam int WAIT_LSB   = 16;
  localparam int HOLD_LSB   = 20;
  localparam int BYP_BIT    = 24;
  localparam int COMMIT_BIT = 25;
  localparam int MAX_CNT_W  = 4;
endpackage

// File: rtl/dcg_regs.sv
`timescale 1ns/1ps
module dcg_regs import dcg_pkg::*; #(
  parameter int NUM_SRC   = 5,
  parameter int CNT_W     = 4,
  parameter bit FIXED_SRC = 1'b0,
  parameter int FIXED_SEL = 4,
  parameter int RESET_SEL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             busy_i,
  input  logic             ack_tgl_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             byp_o,
  output logic [CNT_W-1:0] wait_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             req_tgl_o,
  output logic [31:0]      rd_data_o
);
  localparam int INIT_SEL = FIXED_SRC ? FIXED_SEL : RESET_SEL;
  localparam logic [31:0] USED_MASK =
      (32'((1 << SEL_W) - 1) << SEL_LSB) | (32'((1 << CNT_W) - 1) << WAIT_LSB) |
      (32'((1 << CNT_W) - 1) << HOLD_LSB) | (32'(1) << BYP_BIT) | (32'(1) << COMMIT_BIT);

  logic [SEL_W-1:0] sel_q;
  logic             byp_q, req_q, ack_s1, ack_s2;
  logic [CNT_W-1:0] wait_q, hold_q;
  logic             pending, sel_ok, take;
  logic             unused_wr;

  assign pending   = req_q ^ ack_s2;
  assign sel_ok    = !FIXED_SRC && (int'(wr_data_i[SEL_LSB +: SEL_W]) < NUM_SRC);
  assign take      = wr_data_i[COMMIT_BIT] && !pending;
  assign unused_wr = ^(wr_data_i & ~USED_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_W'(INIT_SEL);
      byp_q  <= 1'b1;
      wait_q <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl_i;
      ack_s2 <= ack_s1;
      if (wr_en_i) begin
        byp_q <= wr_data_i[BYP_BIT];
        if (sel_ok) sel_q <= wr_data_i[SEL_LSB +: SEL_W];
        if (take) begin
          wait_q <= wr_data_i[WAIT_LSB +: CNT_W];
          hold_q <= wr_data_i[HOLD_LSB +: CNT_W];
          req_q  <= ~req_q;
        end
      end
    end
  end

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[SEL_LSB +: SEL_W]     = sel_q;
    rd_data_o[BUSY_BIT]             = busy_i;
    rd_data_o[WAIT_LSB +: CNT_W]    = wait_q;
    rd_data_o[HOLD_LSB +: CNT_W]    = hold_q;
    rd_data_o[BYP_BIT]              = byp_q;
    rd_data_o[COMMIT_BIT]           = pending;
  end

  assign sel_o     = sel_q;
  assign byp_o     = byp_q;
  assign wait_o    = wait_q;
  assign hold_o    = hold_q;
  assign req_tgl_o = req_q;
endmodule

// File: rtl/dcg_clk_switch.sv
`timescale 1ns/1ps
module dcg_clk_switch #(
  parameter int NUM_SRC  = 5,
  parameter int SEL_W    = 3,
  parameter int INIT_SEL = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] src_clk_i,
  output logic               clk_o,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] gate_o
);
  localparam logic [NUM_SRC-1:0] INIT_OH = NUM_SRC'(1) << INIT_SEL;

  logic [NUM_SRC-1:0] want, req_q, fb_s1, fb_s2;

  assign want = NUM_SRC'(1) << sel_i;

  // request opens only once every other gate is seen closed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= INIT_OH;
      fb_s1 <= INIT_OH;
      fb_s2 <= INIT_OH;
    end else begin
      fb_s1 <= gate_o;
      fb_s2 <= fb_s1;
      for (int i = 0; i < NUM_SRC; i++)
        req_q[i] <= want[i] && ((fb_s2 & ~(NUM_SRC'(1) << i)) == '0);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic INIT_ON = (g == INIT_SEL);
    logic s1_q, s2_q, en_q;
    always_ff @(posedge src_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= INIT_ON;
        s2_q <= INIT_ON;
      end else begin
        s1_q <= req_q[g];
        s2_q <= s1_q;
      end
    end
    // gate moves only while its own clock is low
    always_ff @(negedge src_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= INIT_ON;
      else         en_q <= s2_q;
    end
    assign gate_o[g] = en_q;
  end

  assign clk_o  = |(src_clk_i & gate_o);
  assign busy_o = (fb_s2 != want);
endmodule

// File: rtl/dcg_divider.sv
`timescale 1ns/1ps
module dcg_divider #(
  parameter int CNT_W = 4
) (
  input  logic             clk_src_i,
  input  logic             rst_ni,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] wait_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             req_tgl_i,
  output logic             ack_tgl_o,
  output logic             clk_o
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0]    cnt_q, cnt_n, last;
  logic [CNT_W-1:0] wait_a, hold_a, wait_n, hold_n;
  logic             req_s1, req_s2, ack_q, div_q;
  logic             byp_s1, byp_s2, byp_q;
  logic             wrap, apply;

  assign last   = CW'(wait_a) + CW'(hold_a) + CW'(1);
  assign wrap   = (cnt_q == last);
  assign apply  = wrap && (req_s2 != ack_q);
  assign wait_n = apply ? wait_i : wait_a;
  assign hold_n = apply ? hold_i : hold_a;
  assign cnt_n  = wrap ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wait_a <= '0;
      hold_a <= '0;
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_q  <= 1'b0;
      div_q  <= 1'b1;
      byp_s1 <= 1'b1;
      byp_s2 <= 1'b1;
    end else begin
      req_s1 <= req_tgl_i;
      req_s2 <= req_s1;
      byp_s1 <= byp_i;
      byp_s2 <= byp_s1;
      cnt_q  <= cnt_n;
      wait_a <= wait_n;
      hold_a <= hold_n;
      if (apply) ack_q <= req_s2;
      div_q  <= (cnt_n <= CW'(wait_n));
    end
  end

  // bypass changes only when both candidate outputs are low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni)     byp_q <= 1'b1;
    else if (!div_q) byp_q <= byp_s2;
  end

  assign clk_o     = byp_q ? clk_src_i : div_q;
  assign ack_tgl_o = ack_q;
endmodule

// File: rtl/clk_domain_gen.sv
`timescale 1ns/1ps
module clk_domain_gen import dcg_pkg::*; #(
  parameter int NUM_SRC   = 5,
  parameter int CNT_W     = 4,
  parameter bit FIXED_SRC = 1'b0,
  parameter int FIXED_SEL = 4,
  parameter int RESET_SEL = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  output logic               clk_o
);
  localparam int INIT_SEL = FIXED_SRC ? FIXED_SEL : RESET_SEL;

  logic [SEL_W-1:0]   sel;
  logic               byp, req_tgl, ack_tgl, busy, mux_clk;
  logic [CNT_W-1:0]   wait_cnt, hold_cnt;
  logic [NUM_SRC-1:0] src_gate;

  dcg_regs #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .FIXED_SRC(FIXED_SRC),
    .FIXED_SEL(FIXED_SEL), .RESET_SEL(RESET_SEL)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .busy_i(busy), .ack_tgl_i(ack_tgl), .sel_o(sel), .byp_o(byp),
    .wait_o(wait_cnt), .hold_o(hold_cnt), .req_tgl_o(req_tgl), .rd_data_o(rd_data_o)
  );

  dcg_clk_switch #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .INIT_SEL(INIT_SEL)) u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .src_clk_i(src_clk_i),
    .clk_o(mux_clk), .busy_o(busy), .gate_o(src_gate)
  );

  dcg_divider #(.CNT_W(CNT_W)) u_div (
    .clk_src_i(mux_clk), .rst_ni(rst_ni), .byp_i(byp), .wait_i(wait_cnt),
    .hold_i(hold_cnt), .req_tgl_i(req_tgl), .ack_tgl_o(ack_tgl), .clk_o(clk_o)
  );
endmodule

// File: rtl/clk_domain_gen_chk.sv
`timescale 1ns/1ps
module clk_domain_gen_chk #(
  parameter int NUM_SRC   = 5,
  parameter bit FIXED_SRC = 1'b0,
  parameter int FIXED_SEL = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [31:0]        wr_data_i,
  input logic [31:0]        rd_data_o,
  input logic [NUM_SRC-1:0] src_gate_i
);
  logic unused_chk;
  assign unused_chk = ^{wr_data_i, rd_data_o};

  a_r5_one_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_gate_i));

  a_r3_sel_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_data_o[2:0]) < NUM_SRC);

  a_r3_bad_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_data_i[2:0]) >= NUM_SRC) |=> rd_data_o[2:0] == $past(rd_data_o[2:0]));

  a_r9_commit_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[25]) |-> $past(wr_en_i && wr_data_i[25]));

  a_r9_counts_need_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[25]) |=> $stable(rd_data_o[23:16]));

  if (FIXED_SRC) begin : g_fixed
    a_r12_fixed_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(rd_data_o[2:0]) == FIXED_SEL && !rd_data_o[3]);
  end else begin : g_free
    a_r4_busy_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !rd_data_o[3] && int'(wr_data_i[2:0]) < NUM_SRC &&
       wr_data_i[2:0] != rd_data_o[2:0]) |=> rd_data_o[3]);
  end
endmodule

bind clk_domain_gen clk_domain_gen_chk #(
  .NUM_SRC(NUM_SRC), .FIXED_SRC(FIXED_SRC), .FIXED_SEL(FIXED_SEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .src_gate_i(src_gate)
);

// File: tb/sim_clk_domain_gen.sv
`timescale 1ns/1ps
module sim_clk_domain_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
  logic [4:0] src;
  logic wr_en0 = 0, wr_en1 = 0;
  logic [31:0] wr_d0 = '0, wr_d1 = '0, rd0, rd1;
  logic clk0, clk1, mclk;
  int msel = 0;
  int checks = 0, fails = 0;
  real per_tab [5] = '{40.0, 14.0, 6.0, 8.0, 10.0};

  always #2.5 clk = ~clk;
  always #20  s0 = ~s0;
  always #7   s1 = ~s1;
  always #3   s2 = ~s2;
  always #4   s3 = ~s3;
  always #5   s4 = ~s4;
  assign src  = {s4, s3, s2, s1, s0};
  assign mclk = (msel == 0) ? clk0 : clk1;

  clk_domain_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .wr_en_i(wr_en0),
    .wr_data_i(wr_d0), .rd_data_o(rd0), .clk_o(clk0));

  clk_domain_gen #(.CNT_W(3), .FIXED_SRC(1'b1), .FIXED_SEL(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .wr_en_i(wr_en1),
    .wr_data_i(wr_d1), .rd_data_o(rd1), .clk_o(clk1));

  function automatic logic [31:0] cfg(int sel, int byp, int w, int h, int c);
    logic [31:0] r = '0;
    r[2:0]   = 3'(sel);
    r[19:16] = 4'(w);
    r[23:20] = 4'(h);
    r[24]    = byp[0];
    r[25]    = c[0];
    return r;
  endfunction

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_re(string tag, real act, real exp);
    checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      fails++;
      $display("FAIL %s act=%0.3f exp=%0.3f", tag, act, exp);
    end
  endtask

  task automatic wr(int u, logic [31:0] d);
    @(negedge clk);
    if (u == 0) begin wr_en0 = 1; wr_d0 = d; end
    else        begin wr_en1 = 1; wr_d1 = d; end
    @(negedge clk);
    wr_en0 = 0; wr_en1 = 0;
  endtask

  task automatic wait_clear(int u, int bitpos, string tag);
    logic [31:0] v;
    for (int k = 0; k < 4000; k++) begin
      v = (u == 0) ? rd0 : rd1;
      if (!v[bitpos]) break;
      @(negedge clk);
    end
    v = (u == 0) ? rd0 : rd1;
    chk_eq(tag, 32'(v[bitpos]), 32'd0);
  endtask

  task automatic measure(int u, output real hi, output real per);
    realtime t0, t1, t2;
    msel = u;
    repeat (40) @(negedge clk);
    repeat (2) @(posedge mclk);
    t0 = $realtime;
    @(negedge mclk); t1 = $realtime;
    @(posedge mclk); t2 = $realtime;
    hi = t1 - t0;
    per = t2 - t0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    real hi, per;
    int w, h;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 reset word u0", rd0, cfg(1, 1, 0, 0, 0));
    chk_eq("R1 reset word u1", rd1, cfg(4, 1, 0, 0, 0));
    measure(0, hi, per);
    chk_re("R8 bypass osc period", per, per_tab[1]);
    chk_re("R8 bypass osc high", hi, per_tab[1] / 2.0);

    // R2 / R4 walk every source
    for (int s = 0; s < 5; s++) begin
      wr(0, cfg(s, 1, 0, 0, 0));
      if (s != 1) chk_eq("R4 busy after change", 32'(rd0[3]), 32'd1);
      wait_clear(0, 3, "R4 busy clears");
      chk_eq("R2 select readback", rd0, cfg(s, 1, 0, 0, 0));
      measure(0, hi, per);
      chk_re("R2 source period", per, per_tab[s]);
    end
    wr(0, cfg(4, 1, 0, 0, 0));
    chk_eq("R4 same select no busy", 32'(rd0[3]), 32'd0);
    wr(0, cfg(2, 1, 0, 0, 0));
    wait_clear(0, 3, "R4 busy clears to src2");

    // R3 invalid codes
    for (int v = 5; v < 8; v++) begin
      wr(0, cfg(v, 1, 0, 0, 0));
      chk_eq("R3 bad select ignored", rd0, cfg(2, 1, 0, 0, 0));
    end
    measure(0, hi, per);
    chk_re("R3 source kept", per, per_tab[2]);

    // R7 / R6 / R9 full ratio sweep
    for (int r = 2; r <= 32; r++) begin
      w = (r >> 1) - 1;
      h = r - w - 2;
      wr(0, cfg(2, 0, w, h, 1));
      chk_eq("R9 commit pending", 32'(rd0[25]), 32'd1);
      wait_clear(0, 25, "R9 commit clears");
      chk_eq("R9 counts loaded", rd0, cfg(2, 0, w, h, 0));
      measure(0, hi, per);
      chk_re("R7 ratio period", per, r * per_tab[2]);
      chk_re("R7 ratio high", hi, (r >> 1) * per_tab[2]);
    end

    // R6 uneven high/low pairs
    for (int k = 0; k < 3; k++) begin
      w = (k == 0) ? 5 : (k == 1) ? 0 : 15;
      h = (k == 0) ? 0 : (k == 1) ? 7 : 0;
      wr(0, cfg(2, 0, w, h, 1));
      wait_clear(0, 25, "R6 commit clears");
      measure(0, hi, per);
      chk_re("R6 period", per, (w + h + 2) * per_tab[2]);
      chk_re("R6 high", hi, (w + 1) * per_tab[2]);
    end

    // R9 write without commit
    wr(0, cfg(2, 0, 3, 3, 0));
    chk_eq("R9 no commit keeps counts", rd0, cfg(2, 0, 15, 0, 0));
    measure(0, hi, per);
    chk_re("R9 no commit keeps period", per, 17 * per_tab[2]);

    // R10 second commit while pending
    wr(0, cfg(2, 0, 1, 1, 1));
    wr(0, cfg(2, 0, 6, 6, 1));
    wait_clear(0, 25, "R10 commit clears");
    chk_eq("R10 first pair kept", rd0, cfg(2, 0, 1, 1, 0));
    measure(0, hi, per);
    chk_re("R10 period from first pair", per, 4 * per_tab[2]);

    // R8 bypass toggling over a divider setting
    wr(0, cfg(2, 1, 1, 1, 0));
    measure(0, hi, per);
    chk_re("R8 bypass on period", per, per_tab[2]);
    wr(0, cfg(2, 0, 1, 1, 0));
    measure(0, hi, per);
    chk_re("R8 bypass off period", per, 4 * per_tab[2]);

    // R12 / R11 fixed source, narrow counts
    wr(1, cfg(0, 1, 0, 0, 0));
    chk_eq("R12 select write ignored", rd1, cfg(4, 1, 0, 0, 0));
    measure(1, hi, per);
    chk_re("R12 output from source 4", per, per_tab[4]);
    wr(1, cfg(0, 0, 7, 7, 1));
    wait_clear(1, 25, "R11 commit clears");
    chk_eq("R11 max pair readback", rd1, cfg(4, 0, 7, 7, 0));
    measure(1, hi, per);
    chk_re("R11 max ratio period", per, 16 * per_tab[4]);
    chk_re("R11 max ratio high", hi, 8 * per_tab[4]);
    wr(1, cfg(4, 0, 15, 15, 1));
    wait_clear(1, 25, "R11 commit clears again");
    chk_eq("R11 upper count bits read 0", rd1, cfg(4, 0, 7, 7, 0));
    measure(1, hi, per);
    chk_re("R11 ratio capped", per, 16 * per_tab[4]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule